// File: doc/BRIEF.md
# Status Register Protection Controller

This block owns the eight-bit status register of a serial non-volatile memory and rules on every write that reaches the array or the register itself. It keeps two volatile flags, a write-enable latch and a write-in-progress flag, and three persistent bits: a status-write lock and a two-bit block-protect code. The instruction decoder in front of it hands over one-cycle strobes for enable, disable, status write and array page write. It also passes the page write's start address and byte count, a pulse from the array timer when a cycle finishes, and the external write-protect pin level.

Grant and deny outputs are combinational in the cycle of the request, so the decoder can start or drop the array cycle at once. The register updates on the following clock edge. A page write is described by its start address and its length minus one. Inside a page the address wraps, so the highest byte touched is computed from the wrapped span before it is compared with the protected window.

Top module: `sguard`

## Requirements
- R1: The status byte reads {lock, 0, 0, 0, bp1, bp0, wel, wip}: bit 7 is the status-write lock, bits 6:4 are always 0, bits 3:2 are the block-protect code, bit 1 is the write-enable latch and bit 0 is write-in-progress. After a cold reset it reads 0x00.
- R2: An enable strobe sets the write-enable latch and a disable strobe clears it. Either takes effect on the next clock edge.
- R3: A page write is granted only when wel=1, wip=0 and no touched address is protected. Otherwise it is denied, and the register is left unchanged, including wel.
- R4: A granted page write or status write sets wip on the next edge, leaving wel set. A write-done pulse while wip=1 clears both wip and wel on the next edge. A write-done pulse while wip=0 has no effect.
- R5: A granted status write loads only data bits 7, 3 and 2 into the lock and block-protect bits.
- R6: When lock=1 and the write-protect pin is low, a status write is denied and the register stays unchanged. With the pin high, the same status write is granted.
- R7: Block-protect code 00 protects nothing, 01 protects 0x300–0x3FF, 10 protects 0x200–0x3FF and 11 protects the whole space. protHit is 1 for a page write that touches a protected byte.
- R8: A page write covers start..start+len within its 32-byte page and wraps to the page base. For example, 0x2FC with len 7 touches 0x2FC–0x2FF and 0x2E0–0x2E3, which is not protected under code 01.
- R9: A warm reset clears wel and wip and keeps lock and block-protect. A cold reset clears all five bits.
- R10: While wip=1, enable and disable strobes have no effect and every write request is denied.
- R11: When strobes coincide, only the highest-priority one acts, in the order page write, status write, disable, enable. The others are neither granted nor denied and change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous warm reset, active low; clears the volatile bits only |
| coldRstN | input | 1 | Synchronous cold reset, active low; clears every bit |
| wpN | input | 1 | Write-protect pin level; low together with lock=1 freezes the persistent bits |
| enableCmd | input | 1 | Write-enable instruction strobe |
| disableCmd | input | 1 | Write-disable instruction strobe |
| statWrReq | input | 1 | Status write instruction strobe |
| statWrData | input | 8 | Data byte of the status write |
| memWrReq | input | 1 | Page write instruction strobe |
| memWrAddr | input | ADDR_W | Start address of the page write |
| memWrLen | input | PAGE_W | Number of bytes in the page write minus one |
| writeDone | input | 1 | Pulse from the array timer at the end of a write cycle |
| statusByte | output | 8 | Current status register |
| memWrGrant | output | 1 | Page write accepted this cycle |
| memWrDeny | output | 1 | Page write refused this cycle |
| statWrGrant | output | 1 | Status write accepted this cycle |
| statWrDeny | output | 1 | Status write refused this cycle |
| protHit | output | 1 | Page write touches a protected byte |

## Verification
The bench builds the block with its defaults: a 10-bit address and 32-byte pages. This places the quarter and half protection boundaries at 0x300 and 0x200, so one vector can sit just below a boundary and the next just on it. With pages of that size, a start near the end of a page plus a small length wraps. The unwrapped span would cross 0x300 while the wrapped span does not, which separates correct wrap handling from a plain sum.

// File: rtl/sguard_pkg.sv
package sguard_pkg;

  localparam int STAT_W   = 8;
  localparam int BIT_WIP  = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_BP0  = 2;
  localparam int BIT_BP1  = 3;
  localparam int BIT_LOCK = 7;

  // Strobes from control to datapath; each is a one-cycle update order.
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setWip;
    logic clrWip;
    logic loadPersist;
  } sg_strobe_t;

endpackage

// File: rtl/sguard_range.sv
module sguard_range #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [PAGE_W-1:0] lenM1,
  input  logic [1:0]        bpCode,
  output logic              touchesProt
);
  localparam logic [ADDR_W-1:0] QTR_LO  = {2'b11, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] HALF_LO = {1'b1, {(ADDR_W-1){1'b0}}};

  logic [PAGE_W:0]   offSum;
  logic              wraps;
  logic [ADDR_W-1:0] maxTouched;

  always_comb begin
    offSum = {1'b0, startAddr[PAGE_W-1:0]} + {1'b0, lenM1};
    wraps  = offSum[PAGE_W];
    // A wrapping burst reaches the top byte of its page.
    if (wraps) maxTouched = {startAddr[ADDR_W-1:PAGE_W], {PAGE_W{1'b1}}};
    else       maxTouched = {startAddr[ADDR_W-1:PAGE_W], offSum[PAGE_W-1:0]};
  end

  // Protected windows all extend to the top of the space, so the highest
  // touched byte alone decides overlap.
  always_comb begin
    unique case (bpCode)
      2'b00:   touchesProt = 1'b0;
      2'b01:   touchesProt = (maxTouched >= QTR_LO);
      2'b10:   touchesProt = (maxTouched >= HALF_LO);
      default: touchesProt = 1'b1;
    endcase
  end
endmodule

// File: rtl/sguard_dp.sv
module sguard_dp
  import sguard_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coldRstN,
  input  sg_strobe_t        strobe,
  input  logic [STAT_W-1:0] statWrData,
  input  logic              memWrReq,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic [PAGE_W-1:0] memWrLen,
  output logic              wel,
  output logic              wip,
  output logic              lock,
  output logic              hit,
  output logic [STAT_W-1:0] statusByte
);
  logic [1:0] bp;
  logic       rangeHit;

  sguard_range #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uRange (
    .startAddr  (memWrAddr),
    .lenM1      (memWrLen),
    .bpCode     (bp),
    .touchesProt(rangeHit)
  );

  assign hit = memWrReq & rangeHit;

  // Persistent bits: only a cold reset clears them.
  always_ff @(posedge clk) begin
    if (!coldRstN) begin
      lock <= 1'b0;
      bp   <= 2'b00;
    end else if (strobe.loadPersist) begin
      lock <= statWrData[BIT_LOCK];
      bp   <= {statWrData[BIT_BP1], statWrData[BIT_BP0]};
    end
  end

  // Volatile bits: either reset clears them.
  always_ff @(posedge clk) begin
    if (!rstN || !coldRstN) begin
      wel <= 1'b0;
      wip <= 1'b0;
    end else begin
      if (strobe.clrWel)      wel <= 1'b0;
      else if (strobe.setWel) wel <= 1'b1;
      if (strobe.clrWip)      wip <= 1'b0;
      else if (strobe.setWip) wip <= 1'b1;
    end
  end

  always_comb begin
    statusByte           = '0;
    statusByte[BIT_LOCK] = lock;
    statusByte[BIT_BP1]  = bp[1];
    statusByte[BIT_BP0]  = bp[0];
    statusByte[BIT_WEL]  = wel;
    statusByte[BIT_WIP]  = wip;
  end
endmodule

// File: rtl/sguard_ctrl.sv
module sguard_ctrl
  import sguard_pkg::*;
(
  input  logic       wpN,
  input  logic       enableCmd,
  input  logic       disableCmd,
  input  logic       statWrReq,
  input  logic       memWrReq,
  input  logic       writeDone,
  input  logic       wel,
  input  logic       wip,
  input  logic       lock,
  input  logic       hit,
  output logic       memWrGrant,
  output logic       memWrDeny,
  output logic       statWrGrant,
  output logic       statWrDeny,
  output sg_strobe_t strobe
);
  logic statSel, disSel, enSel, hwLock, cycleEnd;

  always_comb begin
    hwLock   = lock & ~wpN;
    cycleEnd = writeDone & wip;

    // Priority: page write, status write, disable, enable.
    memWrGrant  = memWrReq & wel & ~wip & ~hit;
    memWrDeny   = memWrReq & ~memWrGrant;
    statSel     = statWrReq & ~memWrReq;
    statWrGrant = statSel & wel & ~wip & ~hwLock;
    statWrDeny  = statSel & ~statWrGrant;
    disSel      = disableCmd & ~memWrReq & ~statWrReq & ~wip;
    enSel       = enableCmd & ~disableCmd & ~memWrReq & ~statWrReq & ~wip;

    strobe             = '0;
    strobe.setWel      = enSel;
    strobe.clrWel      = disSel | cycleEnd;
    strobe.setWip      = memWrGrant | statWrGrant;
    strobe.clrWip      = cycleEnd;
    strobe.loadPersist = statWrGrant;
  end
endmodule

// File: rtl/sguard.sv
module sguard
  import sguard_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coldRstN,
  input  logic              wpN,
  input  logic              enableCmd,
  input  logic              disableCmd,
  input  logic              statWrReq,
  input  logic [7:0]        statWrData,
  input  logic              memWrReq,
  input  logic [ADDR_W-1:0] memWrAddr,
  input  logic [PAGE_W-1:0] memWrLen,
  input  logic              writeDone,
  output logic [7:0]        statusByte,
  output logic              memWrGrant,
  output logic              memWrDeny,
  output logic              statWrGrant,
  output logic              statWrDeny,
  output logic              protHit
);
  sg_strobe_t strobe;
  logic wel, wip, lock;

  sguard_ctrl uCtrl (
    .wpN(wpN), .enableCmd(enableCmd), .disableCmd(disableCmd),
    .statWrReq(statWrReq), .memWrReq(memWrReq), .writeDone(writeDone),
    .wel(wel), .wip(wip), .lock(lock), .hit(protHit),
    .memWrGrant(memWrGrant), .memWrDeny(memWrDeny),
    .statWrGrant(statWrGrant), .statWrDeny(statWrDeny), .strobe(strobe)
  );

  sguard_dp #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uDp (
    .clk(clk), .rstN(rstN), .coldRstN(coldRstN), .strobe(strobe),
    .statWrData(statWrData), .memWrReq(memWrReq), .memWrAddr(memWrAddr),
    .memWrLen(memWrLen), .wel(wel), .wip(wip), .lock(lock),
    .hit(protHit), .statusByte(statusByte)
  );
endmodule

// File: rtl/sguard_chk.sv
module sguard_chk (
  input logic       clk,
  input logic       rstN,
  input logic       coldRstN,
  input logic       wpN,
  input logic       statWrReq,
  input logic       writeDone,
  input logic [7:0] statusByte,
  input logic       memWrGrant,
  input logic       memWrDeny,
  input logic       statWrGrant,
  input logic       statWrDeny
);
  logic live;
  assign live = rstN & coldRstN;

  // R1
  zero_bits_chk: assert property (@(posedge clk) disable iff (!live)
    statusByte[6:4] == 3'b000);

  // R3
  mem_grant_state_chk: assert property (@(posedge clk) disable iff (!live)
    memWrGrant |-> (statusByte[1] && !statusByte[0]));

  // R3
  mem_excl_chk: assert property (@(posedge clk) disable iff (!live)
    !(memWrGrant && memWrDeny));

  // R4
  wip_rise_chk: assert property (@(posedge clk) disable iff (!live)
    $rose(statusByte[0]) |-> $past(memWrGrant || statWrGrant));

  // R4
  done_clear_chk: assert property (@(posedge clk) disable iff (!live)
    (writeDone && statusByte[0]) |=> (!statusByte[0] && !statusByte[1]));

  // R6
  hw_lock_chk: assert property (@(posedge clk) disable iff (!live)
    (statWrReq && statusByte[7] && !wpN) |-> !statWrGrant);

  // R5
  persist_hold_chk: assert property (@(posedge clk) disable iff (!live)
    !$past(statWrGrant) |-> $stable({statusByte[7], statusByte[3:2]}));

  // R11
  stat_excl_chk: assert property (@(posedge clk) disable iff (!live)
    !(statWrGrant && (statWrDeny || memWrGrant)));
endmodule

bind sguard sguard_chk uChk (
  .clk(clk), .rstN(rstN), .coldRstN(coldRstN), .wpN(wpN),
  .statWrReq(statWrReq), .writeDone(writeDone), .statusByte(statusByte),
  .memWrGrant(memWrGrant), .memWrDeny(memWrDeny),
  .statWrGrant(statWrGrant), .statWrDeny(statWrDeny)
);

// File: tb/sguard_test.sv
module sguard_test;
  localparam int ADDR_W = 10;
  localparam int PAGE_W = 5;

  typedef struct packed {
    logic [3:0]        req;
    logic              en, dis, sw;
    logic [7:0]        swd;
    logic              mw;
    logic [ADDR_W-1:0] addr;
    logic [PAGE_W-1:0] len;
    logic              wp;
    logic              done;
    logic [4:0]        expOut;   // {memGrant, memDeny, statGrant, statDeny, hit}
    logic [7:0]        expStat;
  } vec_t;

  localparam int NV = 29;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1,0,0,8'h00, 0,10'h000,5'd0, 1,0, 5'b00000, 8'h02},
    '{4'd3,  0,0,0,8'h00, 1,10'h010,5'd0, 1,0, 5'b10000, 8'h03},
    '{4'd10, 1,0,0,8'h00, 0,10'h000,5'd0, 1,0, 5'b00000, 8'h03},
    '{4'd10, 0,0,0,8'h00, 1,10'h010,5'd0, 1,0, 5'b01000, 8'h03},
    '{4'd10, 0,1,0,8'h00, 0,10'h000,5'd0, 1,0, 5'b00000, 8'h03},
    '{4'd4,  0,0,0,8'h00, 0,10'h000,5'd0, 1,1, 5'b00000, 8'h00},
    '{4'd3,  0,0,0,8'h00, 1,10'h010,5'd0, 1,0, 5'b01000, 8'h00},
    '{4'd2,  1,0,0,8'h00, 0,10'h000,5'd0, 1,0, 5'b00000, 8'h02},
    '{4'd5,  0,0,1,8'hFF, 0,10'h000,5'd0, 1,0, 5'b00100, 8'h8F},
    '{4'd4,  0,0,0,8'h00, 0,10'h000,5'd0, 1,1, 5'b00000, 8'h8C},
    '{4'd2,  1,0,0,8'h00, 0,10'h000,5'd0, 1,0, 5'b00000, 8'h8E},
    '{4'd7,  0,0,0,8'h00, 1,10'h000,5'd0, 1,0, 5'b01001, 8'h8E},
    '{4'd6,  0,0,1,8'h00, 0,10'h000,5'd0, 0,0, 5'b00010, 8'h8E},
    '{4'd6,  0,0,1,8'h04, 0,10'h000,5'd0, 1,0, 5'b00100, 8'h07},
    '{4'd4,  0,0,0,8'h00, 0,10'h000,5'd0, 1,1, 5'b00000, 8'h04},
    '{4'd2,  1,0,0,8'h00, 0,10'h000,5'd0, 1,0, 5'b00000, 8'h06},
    '{4'd7,  0,0,0,8'h00, 1,10'h2FF,5'd0, 1,0, 5'b10000, 8'h07},
    '{4'd4,  0,0,0,8'h00, 0,10'h000,5'd0, 1,1, 5'b00000, 8'h04},
    '{4'd2,  1,0,0,8'h00, 0,10'h000,5'd0, 1,0, 5'b00000, 8'h06},
    '{4'd7,  0,0,0,8'h00, 1,10'h300,5'd0, 1,0, 5'b01001, 8'h06},
    '{4'd8,  0,0,0,8'h00, 1,10'h2FC,5'd7, 1,0, 5'b10000, 8'h07},
    '{4'd4,  0,0,0,8'h00, 0,10'h000,5'd0, 1,1, 5'b00000, 8'h04},
    '{4'd2,  1,0,0,8'h00, 0,10'h000,5'd0, 1,0, 5'b00000, 8'h06},
    '{4'd11, 0,1,1,8'h0C, 1,10'h000,5'd0, 1,0, 5'b10000, 8'h07},
    '{4'd4,  0,0,0,8'h00, 0,10'h000,5'd0, 1,1, 5'b00000, 8'h04},
    '{4'd2,  1,0,0,8'h00, 0,10'h000,5'd0, 1,0, 5'b00000, 8'h06},
    '{4'd11, 1,1,0,8'h00, 0,10'h000,5'd0, 1,0, 5'b00000, 8'h04},
    '{4'd3,  0,0,0,8'h00, 1,10'h000,5'd0, 1,0, 5'b01000, 8'h04},
    '{4'd4,  0,0,0,8'h00, 0,10'h000,5'd0, 1,1, 5'b00000, 8'h04}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0, coldRstN = 1'b0, wpN = 1'b1;
  logic enableCmd = 1'b0, disableCmd = 1'b0, statWrReq = 1'b0, memWrReq = 1'b0;
  logic writeDone = 1'b0;
  logic [7:0] statWrData = '0;
  logic [ADDR_W-1:0] memWrAddr = '0;
  logic [PAGE_W-1:0] memWrLen = '0;
  logic [7:0] statusByte;
  logic memWrGrant, memWrDeny, statWrGrant, statWrDeny, protHit;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sguard #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uut (
    .clk(clk), .rstN(rstN), .coldRstN(coldRstN), .wpN(wpN),
    .enableCmd(enableCmd), .disableCmd(disableCmd), .statWrReq(statWrReq),
    .statWrData(statWrData), .memWrReq(memWrReq), .memWrAddr(memWrAddr),
    .memWrLen(memWrLen), .writeDone(writeDone), .statusByte(statusByte),
    .memWrGrant(memWrGrant), .memWrDeny(memWrDeny), .statWrGrant(statWrGrant),
    .statWrDeny(statWrDeny), .protHit(protHit)
  );

  function automatic string reqName(input logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Drive at a falling edge, check the combinational verdict, then the
  // register one edge later.
  task automatic step(input vec_t v);
    @(negedge clk);
    enableCmd = v.en; disableCmd = v.dis; statWrReq = v.sw; statWrData = v.swd;
    memWrReq = v.mw; memWrAddr = v.addr; memWrLen = v.len; wpN = v.wp;
    writeDone = v.done;
    #1;
    check(reqName(v.req), "verdict",
          {3'b000, memWrGrant, memWrDeny, statWrGrant, statWrDeny, protHit},
          {3'b000, v.expOut});
    @(negedge clk);
    enableCmd = 0; disableCmd = 0; statWrReq = 0; memWrReq = 0; writeDone = 0;
    memWrAddr = '0; memWrLen = '0; wpN = 1'b1;
    check(reqName(v.req), "status", statusByte, v.expStat);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1; coldRstN = 1'b1;
    @(negedge clk);
    check("R1", "cold reset status", statusByte, 8'h00);  // R1

    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R9: warm reset keeps lock and block-protect, drops wel and wip.
    step('{4'd9, 1,0,0,8'h00, 0,10'h000,5'd0, 1,0, 5'b00000, 8'h06});
    step('{4'd9, 0,0,1,8'h88, 0,10'h000,5'd0, 1,0, 5'b00100, 8'h8B});
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R9", "after warm reset", statusByte, 8'h88);
    // R7 under code 10: 0x1FF free, 0x200 protected.
    step('{4'd2, 1,0,0,8'h00, 0,10'h000,5'd0, 1,0, 5'b00000, 8'h8A});
    step('{4'd7, 0,0,0,8'h00, 1,10'h200,5'd0, 1,0, 5'b01001, 8'h8A});
    step('{4'd7, 0,0,0,8'h00, 1,10'h1FF,5'd0, 1,0, 5'b10000, 8'h8B});
    step('{4'd4, 0,0,0,8'h00, 0,10'h000,5'd0, 1,1, 5'b00000, 8'h88});
    @(negedge clk); coldRstN = 1'b0;
    repeat (3) @(negedge clk);
    coldRstN = 1'b1;
    @(negedge clk);
    check("R9", "after cold reset", statusByte, 8'h00);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule